// File: doc/BRIEF.md
# Receive All-Ones Alarm Detector

This block watches the recovered receive data, one bit per cycle in which the recovery logic flags a valid bit. It reports an alarm indication when the line carries an almost unbroken stream of ones. It does this by counting zeros over back-to-back observation windows of a fixed number of bits. The default is 8192 bits, about 5.3 ms at the 1.544 Mb/s rate, or roughly 99.9 % ones density.

At the end of each window the alarm is re-evaluated. Fewer zeros than the threshold (default nine) raises it, and the threshold or more drops it. Between window ends the alarm holds its value. The alarm is always visible on its own output. It also reaches a pin shared with the negative transmit data path, but only while line coding is enabled. Otherwise that pin carries the transmit data unchanged.

Top module: `ais_density_mon`

## Requirements
- R1: While `rst_n` is low, `ais_o` is 0. Releasing reset starts a fresh window, so the first decision after reset comes after exactly `WIN_BITS` valid bits, and bits received before reset play no part in it.
- R2: A window consists of `WIN_BITS` cycles with `bit_vld` high. Cycles with `bit_vld` low neither advance the window nor count as zeros, whatever `rx_bit` holds.
- R3: If a window ends with fewer than `ZERO_THRESH` bits equal to 0, `ais_o` is 1 in the cycle after the last valid bit of that window.
- R4: If a window ends with `ZERO_THRESH` or more zero bits, `ais_o` is 0 in the cycle after that window's last bit. This holds up to and including a window that is entirely zeros.
- R5: `ais_o` changes only in the cycle after the last valid bit of a window. At all other times it keeps its value.
- R6: Windows do not overlap. Zeros counted in one window never add to the next one.
- R7: When `coder_en` is 1, `tneg_ais_o` equals `ais_o`, with 1 meaning alarm.
- R8: When `coder_en` is 0, `tneg_ais_o` follows `tx_neg_in`, and the alarm keeps being evaluated on `ais_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_vld | input | 1 | Recovered-bit strobe; one received bit per high cycle |
| rx_bit | input | 1 | Recovered data bit, sampled when `bit_vld` is high |
| coder_en | input | 1 | Coder mode; routes the alarm onto the shared pin |
| tx_neg_in | input | 1 | Negative transmit data, passed through when coder mode is off |
| ais_o | output | 1 | Alarm indication, active high |
| tneg_ais_o | output | 1 | Shared pin: alarm in coder mode, transmit data otherwise |

## Verification
The bench builds the block with `WIN_BITS` = 32 and the default `ZERO_THRESH` of 9. With these values every window lasts a few dozen cycles, so many consecutive decisions fit in one short run. The threshold stays at its real value, which lets the run hit exactly eight and exactly nine zeros, zeros at either end of a window, and windows stretched by idle strobes. An all-zero window is also within reach, which pushes the four-bit zero counter deep into saturation.

// File: rtl/ais_pkg.sv
package ais_pkg;

  typedef enum logic {
    ALM_CLEAR  = 1'b0,
    ALM_RAISED = 1'b1
  } alm_state_e;

  function automatic int unsigned cnt_w(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/ais_win_cnt.sv
module ais_win_cnt #(
  parameter int unsigned WIN_BITS = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  output logic win_last
);
  localparam int unsigned WCW = ais_pkg::cnt_w(WIN_BITS - 1);
  localparam logic [WCW-1:0] LAST_IDX = WCW'(WIN_BITS - 1);

  logic [WCW-1:0] idx_q, idx_d;

  always_comb begin
    win_last = bit_vld && (idx_q == LAST_IDX);
    idx_d    = idx_q;
    if (bit_vld) begin
      idx_d = (idx_q == LAST_IDX) ? '0 : idx_q + WCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (bit_vld) idx_q <= idx_d;
  end
endmodule

// File: rtl/ais_zero_cnt.sv
module ais_zero_cnt #(
  parameter int unsigned ZERO_THRESH = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic rx_bit,
  input  logic win_last,
  output logic thresh_met
);
  localparam int unsigned ZCW = ais_pkg::cnt_w(ZERO_THRESH);
  localparam logic [ZCW-1:0] SAT = ZCW'(ZERO_THRESH);

  logic [ZCW-1:0] zc_q, zc_d, zc_incl;
  logic           is_zero;

  always_comb begin
    is_zero = bit_vld && !rx_bit;
    if (is_zero && (zc_q != SAT)) zc_incl = zc_q + ZCW'(1);
    else                          zc_incl = zc_q;
    thresh_met = (zc_incl >= SAT);
    zc_d       = win_last ? '0 : zc_incl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zc_q <= '0;
    else if (bit_vld) zc_q <= zc_d;
  end
endmodule

// File: rtl/ais_alarm.sv
module ais_alarm (
  input  logic clk,
  input  logic rst_n,
  input  logic win_last,
  input  logic thresh_met,
  output logic alarm
);
  import ais_pkg::*;

  alm_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (win_last) st_d = thresh_met ? ALM_CLEAR : ALM_RAISED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ALM_CLEAR;
    else if (win_last) st_q <= st_d;
  end

  assign alarm = (st_q == ALM_RAISED);
endmodule

// File: rtl/ais_density_mon.sv
module ais_density_mon #(
  parameter int unsigned WIN_BITS    = 8192,
  parameter int unsigned ZERO_THRESH = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic rx_bit,
  input  logic coder_en,
  input  logic tx_neg_in,
  output logic ais_o,
  output logic tneg_ais_o
);
  logic win_last;
  logic thresh_met;

  ais_win_cnt #(.WIN_BITS(WIN_BITS)) u_win (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .win_last(win_last)
  );

  ais_zero_cnt #(.ZERO_THRESH(ZERO_THRESH)) u_zero (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .rx_bit(rx_bit),
    .win_last(win_last), .thresh_met(thresh_met)
  );

  ais_alarm u_alm (
    .clk(clk), .rst_n(rst_n), .win_last(win_last),
    .thresh_met(thresh_met), .alarm(ais_o)
  );

  assign tneg_ais_o = coder_en ? ais_o : tx_neg_in;
endmodule

// File: rtl/ais_density_mon_chk.sv
module ais_density_mon_chk #(
  parameter int unsigned WIN_BITS    = 8192,
  parameter int unsigned ZERO_THRESH = 9
) (
  input logic clk,
  input logic rst_n,
  input logic bit_vld,
  input logic rx_bit,
  input logic ais_o
);
  localparam int unsigned PCW = $clog2(WIN_BITS + 1);

  logic [PCW-1:0] pos_q, zeros_q, zeros_tot;
  logic           end_q;
  logic [PCW-1:0] tot_q;

  always_comb zeros_tot = zeros_q + PCW'(bit_vld && !rx_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0; zeros_q <= '0; end_q <= 1'b0; tot_q <= '0;
    end else begin
      end_q <= bit_vld && (pos_q == PCW'(WIN_BITS - 1));
      if (bit_vld) begin
        if (pos_q == PCW'(WIN_BITS - 1)) begin
          pos_q <= '0; zeros_q <= '0; tot_q <= zeros_tot;
        end else begin
          pos_q <= pos_q + PCW'(1); zeros_q <= zeros_tot;
        end
      end
    end
  end

  AST_LOW_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !ais_o); // R1
  AST_SET_BELOW_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (end_q && tot_q < PCW'(ZERO_THRESH)) |-> ais_o); // R3
  AST_CLEAR_AT_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (end_q && tot_q >= PCW'(ZERO_THRESH)) |-> !ais_o); // R4
  AST_HOLD_MID_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !end_q |-> $stable(ais_o)); // R5
endmodule

bind ais_density_mon ais_density_mon_chk #(
  .WIN_BITS(WIN_BITS), .ZERO_THRESH(ZERO_THRESH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .rx_bit(rx_bit), .ais_o(ais_o)
);

// File: tb/ais_density_mon_tb.sv
module ais_density_mon_tb;
  localparam int WIN = 32;
  localparam int THR = 9;
  // entry: nzeros[10:5], zeros_at_end[4], idle_gaps[3], coder[2], txneg[1], exp_ais[0]
  localparam int NV = 9;
  localparam logic [10:0] VEC [NV] = '{
    {6'd0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R3 all ones
    {6'd8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R3 one below threshold
    {6'd9,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R4 exactly threshold
    {6'd8,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1},  // R3/R8 coder off
    {6'd5,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R6 8 at end + 5 at start stay apart
    {6'd32, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R4 all zeros, saturation
    {6'd3,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1},  // R2 idle zeros ignored
    {6'd10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},  // R4/R8 with gaps
    {6'd1,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1}   // R7 back to alarm
  };

  logic clk = 1'b0;
  logic rst_n, bit_vld, rx_bit, coder_en, tx_neg_in;
  logic ais_o, tneg_ais_o;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  ais_density_mon #(.WIN_BITS(WIN), .ZERO_THRESH(THR)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .rx_bit(rx_bit),
    .coder_en(coder_en), .tx_neg_in(tx_neg_in),
    .ais_o(ais_o), .tneg_ais_o(tneg_ais_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic b, input logic gap);
    @(negedge clk); bit_vld = 1'b1; rx_bit = b;
    if (gap) begin
      @(negedge clk); bit_vld = 1'b0; rx_bit = 1'b0;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic prev;
    rst_n = 1'b0; bit_vld = 1'b0; rx_bit = 1'b1; coder_en = 1'b1; tx_neg_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ais in reset", ais_o, 1'b0);
    chk("R7 pin in reset", tneg_ais_o, 1'b0);
    rst_n = 1'b1;
    prev = 1'b0;

    for (int v = 0; v < NV; v++) begin
      int  nz;
      logic at_end, gap, exp;
      nz = int'(VEC[v][10:5]); at_end = VEC[v][4]; gap = VEC[v][3]; exp = VEC[v][0];
      coder_en = VEC[v][2]; tx_neg_in = VEC[v][1];
      for (int i = 0; i < WIN; i++) begin
        logic z;
        z = at_end ? (i >= WIN - nz) : (i < nz);
        if (i == WIN / 2) chk("R5 hold mid window", ais_o, prev);
        send(!z, gap);
      end
      @(negedge clk); bit_vld = 1'b0;
      chk(exp ? "R3 window decision" : "R4 window decision", ais_o, exp);
      chk(coder_en ? "R7 shared pin" : "R8 shared pin", tneg_ais_o,
          coder_en ? exp : tx_neg_in);
      prev = exp;
    end

    // R1: reset mid window restarts the window
    coder_en = 1'b1;
    for (int i = 0; i < 20; i++) send(1'b0, 1'b0);
    @(negedge clk); bit_vld = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears alarm", ais_o, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) send(1'b1, 1'b0);
    @(negedge clk); bit_vld = 1'b0;
    chk("R1 no decision after 12 bits", ais_o, 1'b0);
    for (int i = 0; i < WIN - 12 - 1; i++) send(1'b1, 1'b0);
    @(negedge clk);
    chk("R1 still waiting before last bit", ais_o, 1'b0);
    send(1'b1, 1'b0);
    @(negedge clk); bit_vld = 1'b0;
    chk("R1 first window after reset", ais_o, 1'b1);
    chk("R7 pin follows alarm", tneg_ais_o, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule